// File: doc/BRIEF.md
# PCI Interrupt Link Router

This block takes four PCI interrupt request pins, called links A through D, and steers each one onto a 16-line legacy IRQ bus. Every link has its own trigger mode, chosen between active-low level sensing and active-high rising-edge detection. Every link also has its own 4-bit destination code. A destination code that names an IRQ the router may not drive is treated as "unrouted", and that link then drives nothing.

Software sees one 32-bit configuration dword through a plain register port with byte enables. The trigger-mode bits sit in the low byte and the four destination codes fill the upper half. Each byte lane can be written without disturbing the others.

The pins are asynchronous, so each one passes through a synchronizer before it is detected. Links that point at the same IRQ are OR-ed onto that line.

Top module: `irq_link_router`

## Requirements
- R1: After reset the configuration dword reads 0x00000000 and every bit of `irqOut` is low.
- R2: Configuration bits 3:0 select the trigger mode per link: bit 0 for link A, bit 1 for B, bit 2 for C and bit 3 for D. A value of 0 means active-low level sensing and 1 means rising-edge sensing. The bits read back as written.
- R3: Bits 15:4 of the dword always read as zero, whatever was written to them.
- R4: Byte lane 0 (`cfgByteEn[0]`) writes only the trigger bits. Lanes 2 and 3 write only their own byte of the routing half. Lane 1 changes nothing. A lane whose enable is low keeps its old contents.
- R5: Link A's destination code sits in bits 19:16, link B in 23:20, link C in 27:24 and link D in 31:28. Code n drives IRQ line n (`irqOut[n]`).
- R6: Codes 0, 2, 8 and 13 are reserved. A link that carries one of them drives no line at all.
- R7: In level mode, a routed link holds its line high for as long as its pin is low. The line follows the pin with a latency of two clock edges, set by the two-flop synchronizer.
- R8: In edge mode, a low-to-high transition on the pin gives exactly one clock cycle of high on the line. The pulse starts two edges after the pin rises. A pin that stays high gives no further pulse.
- R9: When several links carry the same code, the line is the OR of their contributions.
- R10: Lines 0, 2, 8 and 13 are never driven high, in accordance with the legal-target mask 0xDEFA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the configuration dword |
| cfgByteEn | input | 4 | Per-byte write enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Current configuration dword (combinational read) |
| linkPin | input | 4 | Raw interrupt pins, bit 0 = link A |
| irqOut | output | 16 | Legacy IRQ lines, bit n = IRQn |

## Verification
The configuration state is visible on the read port, so a wrong stored field shows up there in the cycle after the write that set it. A corrupted lane shows up the same way when a byte-enable write touches a lane it should have left alone. A wrong synchronizer or history flop changes the cycle in which a line rises or falls, or it stretches an edge pulse beyond one cycle; a bench that compares `irqOut` on every cycle catches this within two cycles of the pin change. A decode error drives the wrong line, or a reserved line, as soon as the link becomes active.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_LINKS  = 4;
  localparam int CODE_W     = 4;
  localparam int NUM_IRQ    = 1 << CODE_W;
  localparam int ROUTE_W    = NUM_LINKS * CODE_W;
  localparam logic [NUM_IRQ-1:0] LEGAL_MASK = 16'hDEFA;

  // Configuration handed from the register block to the datapath
  typedef struct packed {
    logic [NUM_LINKS-1:0] edgeMode;
    logic [ROUTE_W-1:0]   routeSel;
  } linkCfg_t;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
  import pirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  output linkCfg_t    linkCfg
);
  localparam int PAD_W = 16 - NUM_LINKS;

  logic [NUM_LINKS-1:0] modeQ;
  logic [ROUTE_W-1:0]   routeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= '0;
    end else if (cfgWrEn && cfgByteEn[0]) begin
      modeQ <= cfgWrData[NUM_LINKS-1:0];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_routeLane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        routeQ[b*8 +: 8] <= '0;
      end else if (cfgWrEn && cfgByteEn[2+b]) begin
        routeQ[b*8 +: 8] <= cfgWrData[16 + b*8 +: 8];
      end
    end
  end

  assign cfgRdData        = {routeQ, {PAD_W{1'b0}}, modeQ};
  assign linkCfg.edgeMode = modeQ;
  assign linkCfg.routeSel = routeQ;
endmodule

// File: rtl/pirq_route_dp.sv
module pirq_route_dp
  import pirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  linkCfg_t             linkCfg,
  input  logic [NUM_LINKS-1:0] linkPin,
  output logic [NUM_IRQ-1:0]   irqOut
);
  logic [NUM_LINKS-1:0] linkActive;

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   pinSync;

    // Reset to the idle-high level so no false event appears after reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncQ <= '1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], linkPin[l]};
        prevQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign pinSync       = syncQ[SYNC_STAGES-1];
    assign linkActive[l] = linkCfg.edgeMode[l] ? (pinSync & ~prevQ) : ~pinSync;
  end

  always_comb begin
    irqOut = '0;
    for (int l = 0; l < NUM_LINKS; l++) begin
      logic [CODE_W-1:0] code;
      code = linkCfg.routeSel[l*CODE_W +: CODE_W];
      if (linkActive[l] && LEGAL_MASK[code]) begin
        irqOut[code] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_link_router.sv
module irq_link_router
  import pirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic [3:0]  linkPin,
  output logic [15:0] irqOut
);
  linkCfg_t linkCfg;

  pirq_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgByteEn (cfgByteEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .linkCfg   (linkCfg)
  );

  pirq_route_dp #(.SYNC_STAGES(2)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .linkCfg (linkCfg),
    .linkPin (linkPin),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/irq_link_router_chk.sv
module irq_link_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfgWrEn,
  input logic [3:0]  cfgByteEn,
  input logic [31:0] cfgRdData,
  input logic [15:0] irqOut
);
  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgRdData[15:4] == 12'h000);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !cfgByteEn[0]) |=> $stable(cfgRdData[3:0]));

  // R4
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgByteEn[3:2] == 2'b00) |=> $stable(cfgRdData[31:16]));

  // R6
  unrouted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgRdData[31:16] == 16'h0000) |-> (irqOut == 16'h0000));

  // R10
  legal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut & 16'h2105) == 16'h0000);
endmodule

bind irq_link_router irq_link_router_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgWrEn   (cfgWrEn),
  .cfgByteEn (cfgByteEn),
  .cfgRdData (cfgRdData),
  .irqOut    (irqOut)
);

// File: tb/sim_irq_link_router.sv
`timescale 1ns/1ps
module sim_irq_link_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgByteEn = 4'h0;
  logic [31:0] cfgWrData = 32'h0;
  logic [31:0] cfgRdData;
  logic [3:0]  linkPin = 4'hF;
  logic [15:0] irqOut;

  int testCount = 0;
  int failCount = 0;

  // Bench-side model state
  logic [3:0]  mMode = 4'h0;
  logic [15:0] mRoute = 16'h0;
  logic [3:0]  m1 = 4'hF, m2 = 4'hF, m3 = 4'hF;

  always #10 clk = ~clk;

  irq_link_router u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .linkPin(linkPin), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mMode = 4'h0; mRoute = 16'h0; m1 = 4'hF; m2 = 4'hF; m3 = 4'hF;
    end else begin
      m3 = m2; m2 = m1; m1 = linkPin;
      if (cfgWrEn) begin
        if (cfgByteEn[0]) mMode = cfgWrData[3:0];
        if (cfgByteEn[2]) mRoute[7:0] = cfgWrData[23:16];
        if (cfgByteEn[3]) mRoute[15:8] = cfgWrData[31:24];
      end
    end
  end

  function automatic logic [15:0] expIrq(logic [3:0] mode, logic [15:0] route,
                                         logic [3:0] cur, logic [3:0] prev);
    logic [15:0] r;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      logic [3:0] code;
      logic act;
      code = route[l*4 +: 4];
      act  = mode[l] ? (cur[l] & ~prev[l]) : ~cur[l];
      if (act && code != 4'd0 && code != 4'd2 && code != 4'd8 && code != 4'd13)
        r[code] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] expRd();
    return {mRoute, 12'h000, mMode};
  endfunction

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkIrq(string tag);
    chk32(tag, {16'h0, irqOut}, {16'h0, expIrq(mMode, mRoute, m2, m3)});
  endtask

  // Drive at negedge, apply at next posedge, return at the following negedge
  task automatic cfgWrite(logic [3:0] be, logic [31:0] d);
    cfgWrEn = 1'b1; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    step(3);
    // R1 reset state
    chk32("R1 rd", cfgRdData, 32'h0);
    chk32("R1 irq", {16'h0, irqOut}, 32'h0);
    rst_n = 1'b1;
    step(2);
    chk32("R1 irq after release", {16'h0, irqOut}, 32'h0);

    // R2 R3 full write, padding reads zero
    cfgWrite(4'hF, 32'hFFFF_FFFF);
    chk32("R2 R3 rd all ones", cfgRdData, 32'hFFFF_000F);
    // R4 lane isolation
    cfgWrite(4'h1, 32'h0000_0000);
    chk32("R4 lane0 only", cfgRdData, 32'hFFFF_0000);
    cfgWrite(4'hC, 32'h1234_0005);
    chk32("R4 route lanes only", cfgRdData, 32'h1234_0000);
    cfgWrite(4'h2, 32'hFFFF_FFFF);
    chk32("R4 lane1 no effect", cfgRdData, 32'h1234_0000);
    cfgWrite(4'h4, 32'h00AB_0000);
    chk32("R4 lane2 only", cfgRdData, 32'h12AB_0000);
    cfgWrite(4'h3, 32'h0000_000A);
    chk32("R2 mode bits", cfgRdData, 32'h12AB_000A);

    // R5 R7 level mode, link A -> IRQ5, two-edge latency
    cfgWrite(4'hF, 32'h0005_0000);
    linkPin = 4'hE;
    step(1);
    chk32("R7 latency one edge", {16'h0, irqOut}, 32'h0);
    step(1);
    chk32("R5 R7 A level IRQ5", {16'h0, irqOut}, 32'h0000_0020);
    step(3);
    chk32("R7 held while low", {16'h0, irqOut}, 32'h0000_0020);
    linkPin = 4'hF;
    step(2);
    chk32("R7 release", {16'h0, irqOut}, 32'h0);

    // R8 edge mode, link B -> IRQ15
    cfgWrite(4'hF, 32'h00F0_0002);
    linkPin = 4'hD;
    step(3);
    chk32("R8 low gives nothing", {16'h0, irqOut}, 32'h0);
    linkPin = 4'hF;
    step(1);
    chk32("R8 not yet", {16'h0, irqOut}, 32'h0);
    step(1);
    chk32("R8 pulse", {16'h0, irqOut}, 32'h0000_8000);
    step(1);
    chk32("R8 single cycle", {16'h0, irqOut}, 32'h0);
    step(3);
    chk32("R8 steady high quiet", {16'h0, irqOut}, 32'h0);

    // R6 reserved codes: links A..D carry 0,2,8,13
    cfgWrite(4'hF, 32'hD820_0000);
    linkPin = 4'h0;
    step(3);
    chk32("R6 reserved codes silent", {16'h0, irqOut}, 32'h0);

    // R9 shared IRQ11 from A and C
    cfgWrite(4'hF, 32'h0B0B_0000);
    linkPin = 4'hB;
    step(3);
    chk32("R9 C alone", {16'h0, irqOut}, 32'h0000_0800);
    linkPin = 4'hA;
    step(3);
    chk32("R9 A and C", {16'h0, irqOut}, 32'h0000_0800);
    linkPin = 4'hE;
    step(3);
    chk32("R9 A alone", {16'h0, irqOut}, 32'h0000_0800);
    linkPin = 4'hF;
    step(3);
    chk32("R9 none", {16'h0, irqOut}, 32'h0);

    // Random phase: R5 R7 R8 R9 R10 against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      linkPin = 4'($urandom());
      if (($urandom() % 10) == 0) begin
        cfgWrEn = 1'b1;
        cfgByteEn = 4'($urandom());
        cfgWrData = $urandom();
      end
      @(negedge clk);
      cfgWrEn = 1'b0;
      cfgByteEn = 4'h0;
      chkIrq("R10 random irq");
      chk32("R4 random rd", cfgRdData, expRd());
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule